// File: doc/BRIEF.md
# Channel Page Address Register File

This block keeps two page bytes, a low one and a high one, for each of four transfer channels, and uses them to turn a channel's 16-bit running offset into a 31-bit physical memory address. Software reaches the page bytes through a byte-wide register port. A 3-bit port offset picks the register and a bank select picks the low or the high set. The offsets are assigned to channels in a fixed, scattered order, and four of the eight offsets reach no channel at all.

On the transfer side, the engine presents a channel index and that channel's current 16-bit offset. The block returns the full address at once. The address is built from, most significant field first, the lower seven bits of the high page, the eight bits of the low page, and the offset. The high bank can be removed by a parameter. When it is removed, the high bank holds no state, reads of it return zero and it adds nothing to the address.

Top module: `pgreg_file`

## Requirements
- R1: After reset every low and every high page byte reads 0x00, and the address equals the zero-extended offset.
- R2: Port offsets reach channels as follows: offset 7 reaches channel 0, offset 3 reaches channel 1, offset 1 reaches channel 2 and offset 2 reaches channel 3. A write on `bus_wr` stores `bus_wdata` into the addressed channel's byte in the selected bank.
- R3: A write to port offset 0, 4, 5 or 6 changes no page byte in either bank.
- R4: A read from port offset 0, 4, 5 or 6 returns 0x00 on `bus_rdata`.
- R5: The bank select (0 = low, 1 = high) picks between two separate register sets that share the same offset-to-channel map. A write to one bank leaves the other bank unchanged.
- R6: `phys_addr` equals {high[6:0], low[7:0], xfer_addr[15:0]} of the channel given by `xfer_chan`, combinationally.
- R7: Bit 7 of a high page byte is stored and read back in full, but it has no effect on `phys_addr`.
- R8: With `HIGH_BANK_EN` = 0, writes to the high bank are dropped, reads of the high bank return 0x00, and `phys_addr[30:24]` is zero.
- R9: A read has no side effect: when no write occurs, all page bytes keep their values and repeated reads return the same data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_bank | input | 1 | Bank select: 0 low page, 1 high page |
| bus_port | input | 3 | Port offset within the page window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the addressed register |
| xfer_chan | input | 2 | Channel whose address is formed |
| xfer_addr | input | 16 | Current offset of that channel |
| phys_addr | output | 31 | Composed physical address |

## Verification
The assertions assume that `bus_port`, `bus_bank` and `bus_wr` are stable between clock edges and free of X after reset. They also assume that only `bus_wr` changes register state, so any cycle without a write must leave both banks unchanged. The stimulus changes inputs only on falling edges and pulses `bus_wr` for exactly one cycle per access. Reads are made with the strobe low, so the bench can observe that reads have no side effect. A second instance built without the high bank receives the same stimulus, which covers the disabled configuration against the same expectations.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  localparam int NUM_CH  = 4;
  localparam int CH_W    = 2;
  localparam int PORT_W  = 3;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } port_map_t;

  // Scattered offset-to-channel assignment; unlisted offsets reach nothing.
  function automatic port_map_t map_port(input logic [PORT_W-1:0] ofs);
    port_map_t m;
    m.hit = 1'b1;
    m.ch  = '0;
    case (ofs)
      3'd7:    m.ch = 2'd0;
      3'd3:    m.ch = 2'd1;
      3'd1:    m.ch = 2'd2;
      3'd2:    m.ch = 2'd3;
      default: m.hit = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pgreg_decode.sv
module pgreg_decode
  import pgreg_pkg::*;
(
  input  logic [PORT_W-1:0] port,
  output logic              hit,
  output logic [CH_W-1:0]   ch
);
  port_map_t m;
  always_comb begin
    m   = map_port(port);
    hit = m.hit;
    ch  = m.ch;
  end
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
  import pgreg_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int N_CH   = NUM_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CH_W-1:0]        ch,
  input  logic [PAGE_W-1:0]      wdata,
  output logic [N_CH*PAGE_W-1:0] q_flat
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [PAGE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= '0;
      else if (we && (ch == CH_W'(g)))      q <= wdata;
    end
    assign q_flat[g*PAGE_W +: PAGE_W] = q;
  end
endmodule

// File: rtl/pgreg_compose.sv
module pgreg_compose
  import pgreg_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int HI_KEEP = 7,
  parameter int OFS_W   = 16,
  parameter int N_CH    = NUM_CH,
  localparam int PHYS_W = HI_KEEP + PAGE_W + OFS_W
) (
  input  logic [N_CH*PAGE_W-1:0] lo_flat,
  input  logic [N_CH*PAGE_W-1:0] hi_flat,
  input  logic [CH_W-1:0]        chan,
  input  logic [OFS_W-1:0]       ofs,
  output logic [PHYS_W-1:0]      phys
);
  function automatic logic [PAGE_W-1:0] pick(input logic [N_CH*PAGE_W-1:0] f,
                                             input logic [CH_W-1:0] c);
    return f[c*PAGE_W +: PAGE_W];
  endfunction

  // Only the lower HI_KEEP bits of the high page take part in the address.
  function automatic logic [PHYS_W-1:0] join_addr(input logic [PAGE_W-1:0] hi,
                                                  input logic [PAGE_W-1:0] lo,
                                                  input logic [OFS_W-1:0]  o);
    return {hi[HI_KEEP-1:0], lo, o};
  endfunction

  always_comb phys = join_addr(pick(hi_flat, chan), pick(lo_flat, chan), ofs);
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int PAGE_W       = 8,
  parameter int HI_KEEP      = 7,
  parameter int OFS_W        = 16,
  parameter bit HIGH_BANK_EN = 1'b1,
  localparam int PHYS_W      = HI_KEEP + PAGE_W + OFS_W,
  localparam int FLAT_W      = NUM_CH * PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_bank,
  input  logic [PORT_W-1:0] bus_port,
  input  logic [PAGE_W-1:0] bus_wdata,
  output logic [PAGE_W-1:0] bus_rdata,
  input  logic [CH_W-1:0]   xfer_chan,
  input  logic [OFS_W-1:0]  xfer_addr,
  output logic [PHYS_W-1:0] phys_addr
);
  logic              map_hit;
  logic [CH_W-1:0]   map_ch;
  logic              lo_we;
  logic              hi_we;
  logic [FLAT_W-1:0] lo_flat;
  logic [FLAT_W-1:0] hi_flat;
  logic [FLAT_W-1:0] rd_bank;

  pgreg_decode u_dec (.port(bus_port), .hit(map_hit), .ch(map_ch));

  assign lo_we = bus_wr && map_hit && !bus_bank;
  assign hi_we = bus_wr && map_hit &&  bus_bank;

  pgreg_bank #(.PAGE_W(PAGE_W), .N_CH(NUM_CH)) u_lo (
    .clk(clk), .rst_n(rst_n), .we(lo_we), .ch(map_ch),
    .wdata(bus_wdata), .q_flat(lo_flat)
  );

  if (HIGH_BANK_EN) begin : g_hi
    pgreg_bank #(.PAGE_W(PAGE_W), .N_CH(NUM_CH)) u_hi (
      .clk(clk), .rst_n(rst_n), .we(hi_we), .ch(map_ch),
      .wdata(bus_wdata), .q_flat(hi_flat)
    );
  end else begin : g_nohi
    logic hi_we_unused;
    assign hi_we_unused = hi_we;
    assign hi_flat      = '0;
  end

  assign rd_bank   = bus_bank ? hi_flat : lo_flat;
  assign bus_rdata = map_hit ? rd_bank[map_ch*PAGE_W +: PAGE_W] : '0;

  pgreg_compose #(
    .PAGE_W(PAGE_W), .HI_KEEP(HI_KEEP), .OFS_W(OFS_W), .N_CH(NUM_CH)
  ) u_cmp (
    .lo_flat(lo_flat), .hi_flat(hi_flat), .chan(xfer_chan),
    .ofs(xfer_addr), .phys(phys_addr)
  );
endmodule

// File: rtl/pgreg_file_chk.sv
module pgreg_file_chk #(
  parameter int PAGE_W  = 8,
  parameter int HI_KEEP = 7,
  parameter int OFS_W   = 16,
  parameter bit HIGH_EN = 1'b1,
  parameter int FLAT_W  = 32,
  parameter int PHYS_W  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_bank,
  input logic [PAGE_W-1:0] bus_rdata,
  input logic [OFS_W-1:0]  xfer_addr,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              map_hit,
  input logic [FLAT_W-1:0] lo_flat,
  input logic [FLAT_W-1:0] hi_flat
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (lo_flat == '0 && hi_flat == '0));

  a_r3_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !map_hit) |=> ($stable(lo_flat) && $stable(hi_flat)));

  a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !map_hit |-> (bus_rdata == '0));

  a_r5_low_write_spares_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bank) |=> $stable(hi_flat));

  a_r5_high_write_spares_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_bank) |=> $stable(lo_flat));

  a_r6_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == xfer_addr);

  a_r9_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(lo_flat) && $stable(hi_flat)));

  a_r8_no_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !HIGH_EN |-> (hi_flat == '0 && phys_addr[PHYS_W-1 -: HI_KEEP] == '0));
endmodule

bind pgreg_file pgreg_file_chk #(
  .PAGE_W(PAGE_W), .HI_KEEP(HI_KEEP), .OFS_W(OFS_W),
  .HIGH_EN(HIGH_BANK_EN), .FLAT_W(FLAT_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
  .bus_rdata(bus_rdata), .xfer_addr(xfer_addr), .phys_addr(phys_addr),
  .map_hit(map_hit), .lo_flat(lo_flat), .hi_flat(hi_flat)
);

// File: tb/pgreg_file_tb.sv
module pgreg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_bank = 1'b0;
  logic [2:0]  bus_port = '0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  xfer_chan = '0;
  logic [15:0] xfer_addr = '0;
  logic [7:0]  rd_a, rd_b;
  logic [30:0] pa_a, pa_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int chan_of [8] = '{-1, 2, 3, 1, -1, -1, -1, 0};
  int exp_lo [4];
  int exp_hi [4];

  always #5 clk = ~clk;

  pgreg_file u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
    .xfer_chan(xfer_chan), .xfer_addr(xfer_addr), .phys_addr(pa_a)
  );

  pgreg_file #(.HIGH_BANK_EN(1'b0)) u_nohi (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
    .xfer_chan(xfer_chan), .xfer_addr(xfer_addr), .phys_addr(pa_b)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input bit bank, input int port, input int data);
    @(negedge clk);
    bus_bank = bank; bus_port = 3'(port); bus_wdata = 8'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (chan_of[port] >= 0) begin
      if (bank) exp_hi[chan_of[port]] = data & 255;
      else      exp_lo[chan_of[port]] = data & 255;
    end
  endtask

  function automatic int exp_read(input bit bank, input int port, input bit hi_on);
    if (chan_of[port] < 0) return 0;
    if (bank) return hi_on ? exp_hi[chan_of[port]] : 0;
    return exp_lo[chan_of[port]];
  endfunction

  // Read sweep over both banks and all eight offsets, on both instances.
  task automatic sweep_reads(input string req);
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        bus_bank = b[0]; bus_port = 3'(p);
        #1;
        chk(req, rd_a, exp_read(b[0], p, 1'b1));
        chk({req, " R8"}, rd_b, exp_read(b[0], p, 1'b0));
        #1;
        chk({req, " R9"}, rd_a, exp_read(b[0], p, 1'b1));
      end
    end
  endtask

  task automatic sweep_addr(input string req);
    int offs [4] = '{0, 65535, 4660, 32769};
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        xfer_chan = 2'(c); xfer_addr = 16'(offs[k]);
        #1;
        chk(req, pa_a, longint'(exp_hi[c] % 128) * 64'd16777216
                       + longint'(exp_lo[c]) * 64'd65536 + offs[k]);
        chk({req, " R8"}, pa_b, longint'(exp_lo[c]) * 64'd65536 + offs[k]);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin exp_lo[c] = 0; exp_hi[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    sweep_reads("R1");
    sweep_addr("R1");
    // R2 R3 R5: each offset written in each bank with distinct values
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 8; p++)
        wr(b[0], p, ((p + 1) * 17) ^ (b ? 192 : 0));
    sweep_reads("R2 R3 R4 R5");
    sweep_addr("R6 R7");
    // R5: low-bank rewrite must leave high bank as is
    wr(1'b0, 7, 8'h5A);
    wr(1'b0, 3, 8'hA5);
    sweep_reads("R5");
    // R7: high byte with bit 7 set and clear, same low bits
    wr(1'b1, 1, 8'hFF);
    wr(1'b1, 2, 8'h7F);
    sweep_reads("R7");
    sweep_addr("R6 R7");
    // R3: unmapped offsets hammered with all-ones
    for (int b = 0; b < 2; b++)
      foreach (chan_of[p]) if (chan_of[p] < 0) wr(b[0], p, 8'hFF);
    sweep_reads("R3 R4");
    sweep_addr("R3 R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule